// File: doc/BRIEF.md
# Quadrature Encoder Decoder with Position and Speed Capture

This block turns the two phase signals and the index signal of an incremental rotary or linear encoder into a signed-direction position count and a speed figure. Each encoder input passes through a two-flop synchronizer. The decoder then looks at every edge of both phases, which gives four counts per encoder line. It reports which way each step moved and flags any sample in which both phases changed at once. That double change is an illegal transition and is not counted.

A position register counts up or down with each valid step. It wraps between zero and a programmable top value, and it can optionally be cleared by the rising edge of the index input. A speed timer runs over a programmable number of clock cycles. At the end of each window it latches the number of valid steps seen during that window. Four sticky event flags are kept for an index edge, a window expiry, a reversal of direction and an illegal transition. A mask register decides which flags drive the interrupt line. Software reads and writes all of this over a small word-addressed register bus.

Top module: `quad_enc_top`

## Requirements
- R1: After reset every register reads zero. This covers position, top value, window, speed, mask, flags and status, and the interrupt line is low.
- R2: Phase pairs are written (A,B). The sequence 00→10→11→01→00 adds one per step and the reverse sequence subtracts one per step. Status register (address 7) bit 0 reads 1 after a downward step and 0 after an upward step.
- R3: Counting up from the top value (address 1) gives 0. Counting down from 0 gives the top value.
- R4: A sample in which both phases changed leaves the position and the speed count unchanged, and it sets flag bit 3.
- R5: With control bit 1 set, the two phases are exchanged before decoding, so the direction of counting is reversed.
- R6: A rising index edge sets flag bit 0. With control bit 2 set, the same edge also clears the position, and this takes priority over a step in the same cycle.
- R7: With a window length W at address 3, a window ends every max(W,1) cycles. At that point the speed register (address 4) takes the number of valid steps in the window, including a step in the last cycle, and flag bit 1 is set.
- R8: A valid step whose direction differs from the status direction sets flag bit 2.
- R9: Flags (address 6) are sticky, and writing 1 to a bit clears it unless the same event recurs in that cycle. The interrupt line is high exactly when some flag bit is set whose mask bit (address 5) is also set.
- R10: Steps arriving on consecutive clock cycles, which is one quarter of the clock rate per phase, are each counted.
- R11: With control bit 0 (enable) clear, no step, index edge or window event has any effect, and the window timer and step count are held at zero.
- R12: A write to address 2 loads the position, and it takes priority over decoder activity in that cycle. Reads are combinational from the word address; control is at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder index pulse, asynchronous |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq | output | 1 | Masked OR of the event flags |

## Verification
Several cases are hard to reach from the pins because of the three-cycle path from input to register. These are a step that coincides with a window expiry, an index clear that coincides with a step, and a flag clear that coincides with the same event recurring. The stimulus drives the phases at full rate, one edge per clock, so that step events fall on every cycle, including the last cycle of a short window and the cycle of an index edge. Reversals come straight after a wrap, and illegal transitions are made by toggling both phases in the same cycle. A behavioural model replays each pin sample through its own delay line and compares the selected register and the interrupt line on every clock.

// File: rtl/quad_enc_pkg.sv
package quad_enc_pkg;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TOP   = 3'd1,
    A_POS   = 3'd2,
    A_WIN   = 3'd3,
    A_SPEED = 3'd4,
    A_MASK  = 3'd5,
    A_FLAG  = 3'd6,
    A_STAT  = 3'd7
  } reg_addr_e;

  localparam int NFLAG = 4;
  localparam int F_IDX = 0;
  localparam int F_WIN = 1;
  localparam int F_DIR = 2;
  localparam int F_ERR = 3;

  localparam int C_EN   = 0;
  localparam int C_SWAP = 1;
  localparam int C_ICLR = 2;
  localparam int CTRL_W = 3;

  // Direction of a single-phase change: 1 means count up.
  function automatic logic step_is_up(logic a_changed, logic a_now, logic b_now);
    return a_changed ? (a_now != b_now) : (a_now == b_now);
  endfunction

  // Next position with wrap between 0 and top.
  function automatic logic [31:0] wrap_next(logic [31:0] cur, logic [31:0] top, logic up);
    if (up) return (cur == top) ? 32'd0 : cur + 32'd1;
    else    return (cur == 32'd0) ? top : cur - 32'd1;
  endfunction

endpackage

// File: rtl/quad_enc_sync.sv
module quad_enc_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/quad_enc_decode.sv
module quad_enc_decode
  import quad_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic swap,
  input  logic a_in,
  input  logic b_in,
  input  logic idx_in,
  output logic step,
  output logic up,
  output logic err,
  output logic idx_rise
);
  logic a, b, a_q, b_q, idx_q;
  logic a_chg, b_chg;

  assign a = swap ? b_in : a_in;
  assign b = swap ? a_in : b_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= 1'b0;
      b_q   <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      a_q   <= a;
      b_q   <= b;
      idx_q <= idx_in;
    end
  end

  assign a_chg    = a ^ a_q;
  assign b_chg    = b ^ b_q;
  assign step     = en & (a_chg ^ b_chg);
  assign err      = en & a_chg & b_chg;
  assign up       = step_is_up(a_chg, a, b);
  assign idx_rise = en & idx_in & ~idx_q;
endmodule

// File: rtl/quad_enc_posn.sv
module quad_enc_posn
  import quad_enc_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic             idx_clr,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic [POS_W-1:0] top,
  output logic [POS_W-1:0] pos
);
  logic [31:0] nxt;
  assign nxt = wrap_next(32'(pos), 32'(top), up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (load)    pos <= load_val;
    else if (idx_clr) pos <= '0;
    else if (step)    pos <= nxt[POS_W-1:0];
  end
endmodule

// File: rtl/quad_enc_speed.sv
module quad_enc_speed #(
  parameter int TIM_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [TIM_W-1:0] win,
  output logic [CNT_W-1:0] speed,
  output logic             expire
);
  logic [TIM_W-1:0] timer;
  logic [CNT_W-1:0] cnt;
  logic [TIM_W:0]   t_plus;
  logic [CNT_W-1:0] cnt_inc;

  assign t_plus  = {1'b0, timer} + 1'b1;
  assign expire  = en & (t_plus >= {1'b0, win});
  assign cnt_inc = cnt + CNT_W'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      cnt   <= '0;
      speed <= '0;
    end else if (!en) begin
      timer <= '0;
      cnt   <= '0;
    end else if (expire) begin
      timer <= '0;
      cnt   <= '0;
      speed <= cnt_inc;
    end else begin
      timer <= timer + 1'b1;
      cnt   <= cnt_inc;
    end
  end
endmodule

// File: rtl/quad_enc_top.sv
module quad_enc_top
  import quad_enc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 16,
  parameter int TIM_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [2:0]       syn;
  logic [CTRL_W-1:0] ctrl_q;
  logic [POS_W-1:0] top_q, pos_q;
  logic [TIM_W-1:0] win_q;
  logic [CNT_W-1:0] speed_q;
  logic [NFLAG-1:0] mask_q, flag_q, flag_set, flag_clr;
  logic             dir_q;
  logic             ev_step, ev_up, ev_err, ev_idx, ev_expire, ev_dirchg;
  logic             wr_en, pos_load, idx_clr, ctrl_en;

  quad_enc_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({enc_idx, enc_b, enc_a}), .q(syn)
  );

  assign ctrl_en = ctrl_q[C_EN];

  quad_enc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .swap(ctrl_q[C_SWAP]),
    .a_in(syn[0]), .b_in(syn[1]), .idx_in(syn[2]),
    .step(ev_step), .up(ev_up), .err(ev_err), .idx_rise(ev_idx)
  );

  assign wr_en    = bus_sel & bus_wr;
  assign pos_load = wr_en & (bus_addr == A_POS);
  assign idx_clr  = ev_idx & ctrl_q[C_ICLR];

  quad_enc_posn #(.POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(ev_step), .up(ev_up),
    .idx_clr(idx_clr), .load(pos_load), .load_val(bus_wdata[POS_W-1:0]),
    .top(top_q), .pos(pos_q)
  );

  quad_enc_speed #(.TIM_W(TIM_W), .CNT_W(CNT_W)) u_spd (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .step(ev_step),
    .win(win_q), .speed(speed_q), .expire(ev_expire)
  );

  assign ev_dirchg = ev_step & (dir_q != ~ev_up);

  always_comb begin
    flag_set        = '0;
    flag_set[F_IDX] = ev_idx;
    flag_set[F_WIN] = ev_expire;
    flag_set[F_DIR] = ev_dirchg;
    flag_set[F_ERR] = ev_err;
    flag_clr = (wr_en && bus_addr == A_FLAG) ? bus_wdata[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '0;
      win_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (ev_step) dir_q <= ~ev_up;
      if (wr_en) begin
        case (bus_addr)
          A_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
          A_TOP:  top_q  <= bus_wdata[POS_W-1:0];
          A_WIN:  win_q  <= bus_wdata[TIM_W-1:0];
          A_MASK: mask_q <= bus_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      A_TOP:   bus_rdata = DATA_W'(top_q);
      A_POS:   bus_rdata = DATA_W'(pos_q);
      A_WIN:   bus_rdata = DATA_W'(win_q);
      A_SPEED: bus_rdata = DATA_W'(speed_q);
      A_MASK:  bus_rdata = DATA_W'(mask_q);
      A_FLAG:  bus_rdata = DATA_W'(flag_q);
      default: bus_rdata = DATA_W'(dir_q);
    endcase
  end

  assign irq = |(flag_q & mask_q);
endmodule

// File: rtl/quad_enc_chk.sv
module quad_enc_chk #(
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             step,
  input logic             up,
  input logic             err,
  input logic             expire,
  input logic             pos_load,
  input logic             idx_clr,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] top,
  input logic [3:0]       flags
);
  p_err_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !step);

  p_err_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> flags[3]);

  p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && pos == top && !pos_load && !idx_clr) |=> pos == '0);

  p_wrap_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !up && pos == '0 && !pos_load && !idx_clr) |=> pos == $past(top));

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up && pos != top && !pos_load && !idx_clr) |=> pos == $past(pos) + 1'b1);

  p_window_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flags[1]);

  p_hold_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pos_load) |=> $stable(pos));
endmodule

bind quad_enc_top quad_enc_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_en), .step(ev_step), .up(ev_up),
  .err(ev_err), .expire(ev_expire), .pos_load(pos_load), .idx_clr(idx_clr),
  .pos(pos_q), .top(top_q), .flags(flag_q)
);

// File: tb/test_quad_enc_top.sv
`timescale 1ns/1ps
module test_quad_enc_top;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0;
  logic enc_a = 0, enc_b = 0, enc_idx = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 3'd2;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq;

  always #10 clk = ~clk;

  quad_enc_top i_quad_enc_top (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int vectors = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  // behavioural model state
  int m_ctrl, m_top, m_pos, m_win, m_speed, m_mask, m_flag, m_dir;
  int m_tmr, m_cnt;
  bit q_a[$], q_b[$], q_i[$];
  bit p_a, p_b, p_i;

  function automatic int model_read(int adr);
    case (adr)
      0: return m_ctrl; 1: return m_top; 2: return m_pos; 3: return m_win;
      4: return m_speed; 5: return m_mask; 6: return m_flag;
      default: return m_dir;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_top = 0; m_pos = 0; m_win = 0; m_speed = 0; m_mask = 0;
      m_flag = 0; m_dir = 0; m_tmr = 0; m_cnt = 0; p_a = 0; p_b = 0; p_i = 0;
      q_a = '{0, 0}; q_b = '{0, 0}; q_i = '{0, 0};
    end else begin
      bit ra, rb, ri, a, b, ac, bc, en, stp, er, upd, ir, ex;
      int set, wv;
      ra = q_a[0]; rb = q_b[0]; ri = q_i[0];
      a = m_ctrl[1] ? rb : ra;
      b = m_ctrl[1] ? ra : rb;
      en = m_ctrl[0];
      ac = a != p_a; bc = b != p_b;
      stp = en && (ac != bc);
      er = en && ac && bc;
      upd = ac ? (a != b) : (a == b);
      ir = en && ri && !p_i;
      ex = 0;
      set = 0;
      if (ir) set |= 1;
      if (stp && (m_dir != (upd ? 0 : 1))) set |= 4;
      if (er) set |= 8;
      if (!en) begin m_tmr = 0; m_cnt = 0; end
      else if (m_tmr + 1 >= m_win) begin
        ex = 1; m_speed = (m_cnt + stp) & 16'hffff; m_cnt = 0; m_tmr = 0;
      end else begin m_tmr++; m_cnt = (m_cnt + stp) & 16'hffff; end
      if (ex) set |= 2;
      wv = int'(bus_wdata);
      if (bus_sel && bus_wr && bus_addr == 2) m_pos = wv & 16'hffff;
      else if (ir && m_ctrl[2]) m_pos = 0;
      else if (stp) begin
        if (upd) m_pos = (m_pos == m_top) ? 0 : m_pos + 1;
        else     m_pos = (m_pos == 0) ? m_top : m_pos - 1;
      end
      if (stp) m_dir = upd ? 0 : 1;
      if (bus_sel && bus_wr && bus_addr == 6) m_flag &= ~(wv & 15);
      m_flag |= set;
      if (bus_sel && bus_wr) case (bus_addr)
        0: m_ctrl = wv & 7;
        1: m_top = wv & 16'hffff;
        3: m_win = wv & 16'hffff;
        5: m_mask = wv & 15;
        default: ;
      endcase
      p_a = a; p_b = b; p_i = ri;
      void'(q_a.pop_front()); void'(q_b.pop_front()); void'(q_i.pop_front());
      q_a.push_back(enc_a); q_b.push_back(enc_b); q_i.push_back(enc_idx);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_r;
      bit exp_i;
      exp_r = model_read(int'(bus_addr));
      exp_i = (m_flag & m_mask) != 0;
      vectors++;
      if (bus_rdata != DW'(exp_r) || irq != exp_i) begin
        fails++;
        $display("FAIL %s addr=%0d rdata=%0d exp=%0d irq=%0b exp=%0b",
                 req, bus_addr, bus_rdata, exp_r, irq, exp_i);
      end
    end
  end

  int ph = 0;
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #2;
  endtask
  task automatic put_ph();
    case (ph)
      0: begin enc_a = 0; enc_b = 0; end
      1: begin enc_a = 1; enc_b = 0; end
      2: begin enc_a = 1; enc_b = 1; end
      default: begin enc_a = 0; enc_b = 1; end
    endcase
  endtask
  task automatic steps(int n, bit fwd, int gap);
    for (int i = 0; i < n; i++) begin
      ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
      put_ph();
      tick(gap);
    end
  endtask
  task automatic wr(int adr, int val);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'(adr); bus_wdata = DW'(val);
    tick();
    bus_wr = 0; bus_wdata = '0;
  endtask
  task automatic look(int adr, int n);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'(adr);
    tick(n);
  endtask
  task automatic sweep();
    for (int k = 0; k < 8; k++) look(k, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    req = "R1"; sweep();
    req = "R9"; wr(5, 15); wr(1, 9); wr(3, 20); wr(0, 1);
    req = "R3"; look(2, 1); steps(15, 1, 3); look(2, 4);
    req = "R2"; steps(15, 0, 3); look(7, 4); look(2, 2);
    req = "R8"; look(6, 2); steps(2, 1, 4); look(6, 2); look(7, 2);
    req = "R9"; wr(6, 15); look(6, 2);
    req = "R10"; look(2, 1); steps(12, 1, 1); look(2, 4); steps(12, 0, 1); look(2, 4);
    req = "R7"; look(4, 1); steps(40, 1, 1); look(4, 4); steps(10, 1, 2); look(4, 25);
    req = "R4"; wr(6, 15); look(2, 1);
    enc_a = ~enc_a; enc_b = ~enc_b; ph = (ph + 2) % 4;
    look(2, 4); look(6, 2); look(4, 22);
    req = "R9"; wr(5, 1); wr(6, 14); look(6, 3); wr(6, 1); look(6, 2);
    req = "R6"; wr(5, 15); enc_idx = 1; look(6, 4); enc_idx = 0; look(2, 2);
    wr(0, 5); steps(3, 1, 2); look(2, 1); enc_idx = 1; steps(4, 1, 1); look(2, 4);
    enc_idx = 0; look(2, 2);
    req = "R5"; wr(0, 3); look(2, 2); steps(5, 1, 2); look(2, 3); look(7, 2);
    req = "R11"; wr(0, 0); wr(6, 15); steps(6, 1, 2); enc_idx = 1; look(2, 4);
    enc_idx = 0; look(6, 2); look(4, 30);
    req = "R12"; wr(0, 1); wr(2, 7); look(2, 1); steps(3, 0, 1);
    wr(2, 4); look(2, 4);
    req = "R7"; wr(3, 0); look(4, 2); steps(6, 1, 1); look(4, 3); wr(3, 3); steps(9, 1, 1); look(4, 5);
    req = "R3"; wr(1, 2); wr(2, 0); steps(8, 0, 1); look(2, 4); steps(8, 1, 2); look(2, 4);
    tick(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule